// File: doc/BRIEF.md
# External Bus Cycle Wait Controller

This block turns one CPU memory request into external bus strobes. It drives an address-latch enable, an active-low enable strobe, and separate active-low write strobes for the low and high byte lanes. It also gives the byte address of each cycle, the byte lanes in use, and a one-clock completion pulse. A request carries an address, a read/write flag and a size flag (byte or 16-bit word). The block also samples two mode bits, the width of the external bus (8 or 16 bits) and a decode that says whether the address falls in the on-chip area.

A word goes out as one bus cycle only when the bus is 16 bits wide and the address is even. Any other word becomes two single-byte cycles: the requested address first, then the next address. No byte-high-enable pin is driven. The write strobe of each lane carries that information instead.

The enable strobe can be stretched to give slow external devices more time, and there are two ways to stretch it. In the 1.5x style only the low phase of the enable strobe is lengthened. In the 2x style the address-latch phase and the enable-low phase are both lengthened. Stretching never applies to the on-chip area, and a global wait-disable bit turns it off for every area.

Top module: `ebc_ctrl`

## Requirements
- R1: While reset is held, and when no request is in progress, `ale`=0, `en_n`=1, `we_lo_n`=1, `we_hi_n`=1, `lane_sel`=2'b00 and `done`=0.
- R2: An access that is not stretched is `ale` high for 2 clocks, then `en_n` low for 2 clocks. `ale` and a low `en_n` never overlap.
- R3: With `wait_dis`=0, `wait_mode`=1 and an external address (`addr_internal`=0), `ale` is high for 2 clocks and `en_n` is low for 4 clocks in each byte cycle.
- R4: With `wait_dis`=0, `wait_mode`=0 and an external address, `ale` is high for 4 clocks and `en_n` is low for 4 clocks in each byte cycle.
- R5: When `addr_internal`=1, or when `wait_dis`=1, the timing of R2 is used whatever `wait_mode` is.
- R6: A word request (`req_word`=1) with `bus16`=1 and `req_addr[0]`=0 runs as one bus cycle with `lane_sel`=2'b11 and `cyc_addr` equal to the request address.
- R7: Any other word request runs as two consecutive byte cycles. `cyc_addr` is the request address in the first cycle and that address plus one, modulo 2^ADDR_W, in the second. A byte request is one cycle at its own address.
- R8: In a byte cycle, `lane_sel` is 2'b10 (high lane) when `bus16`=1 and `cyc_addr[0]`=1. Otherwise it is 2'b01 (low lane). `lane_sel` bit 0 is the low lane and bit 1 is the high lane.
- R9: For a write, `we_lo_n` and `we_hi_n` go low exactly while `en_n` is low, each one only if its lane bit in `lane_sel` is set. For a read, both stay high.
- R10: `done` is high for exactly one clock, in the last clock that `en_n` is low in the final byte cycle of a request. In the next clock the block is idle.
- R11: A request is accepted only on a rising edge when the block is idle and `req_valid`=1. All request fields, mode bits, `bus16` and `addr_internal` are captured at that edge. Changes to them, and a held `req_valid`, have no effect until the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| wait_dis | input | 1 | 1 = never stretch |
| wait_mode | input | 1 | 1 = stretch enable-low only (1.5x), 0 = stretch both phases (2x) |
| bus16 | input | 1 | 1 = external data bus is 16 bits wide |
| addr_internal | input | 1 | 1 = address is in the on-chip area |
| ale | output | 1 | Address latch enable |
| en_n | output | 1 | Active-low enable strobe |
| we_lo_n | output | 1 | Active-low low-lane write strobe |
| we_hi_n | output | 1 | Active-low high-lane write strobe |
| lane_sel | output | 2 | Byte lanes of the current cycle |
| cyc_addr | output | ADDR_W | Byte address of the current cycle |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench tries every combination of direction, size, the two mode bits, bus width, area decode and address parity. For each one it compares the strobe trace clock by clock with phase lengths computed from the rules. This separates the three timing shapes and shows that the area decode and the wait-disable bit each override the mode bit on their own. The parity and width combinations separate single-word cycles from split cycles, and high-lane byte cycles from low-lane ones. A request at the top address checks that the second address wraps. Every field is inverted and `req_valid` is held high while each transfer runs, so a block that re-samples its inputs gives a different trace.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_STRB = 2'd2
   } ebc_phase_e;

   // lane bit 0 = low byte lane, bit 1 = high byte lane
   function automatic logic [1:0] lane_of(input logic whole_word,
                                          input logic wide_bus,
                                          input logic odd_byte);
      if (whole_word)              return 2'b11;
      else if (wide_bus && odd_byte) return 2'b10;
      else                         return 2'b01;
   endfunction

endpackage

// File: rtl/ebc_plan.sv
module ebc_plan (
   input  logic word,
   input  logic addr0,
   input  logic bus16,
   input  logic wait_dis,
   input  logic internal,
   output logic split,
   output logic stretch
);
   logic whole_ok;

   always_comb begin
      whole_ok = bus16 && !addr0;
      split    = word && !whole_ok;
      stretch  = !wait_dis && !internal;
   end
endmodule

// File: rtl/ebc_phase_timer.sv
module ebc_phase_timer #(
   parameter int ALE_CLKS  = 2,
   parameter int STRB_CLKS = 2,
   parameter int MULT      = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic in_strb,
   input  logic stretch,
   input  logic lo_only,
   output logic expire
);
   localparam int MAX_BASE = (ALE_CLKS > STRB_CLKS) ? ALE_CLKS : STRB_CLKS;
   localparam int MAX_LEN  = MAX_BASE * MULT;
   localparam int CNT_W    = $clog2(MAX_LEN + 1);

   localparam logic [CNT_W-1:0] ADDR_SHORT = CNT_W'(ALE_CLKS - 1);
   localparam logic [CNT_W-1:0] ADDR_LONG  = CNT_W'(ALE_CLKS * MULT - 1);
   localparam logic [CNT_W-1:0] STRB_SHORT = CNT_W'(STRB_CLKS - 1);
   localparam logic [CNT_W-1:0] STRB_LONG  = CNT_W'(STRB_CLKS * MULT - 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;

   always_comb begin
      if (in_strb)
         last = stretch ? STRB_LONG : STRB_SHORT;
      else
         last = (stretch && !lo_only) ? ADDR_LONG : ADDR_SHORT;
      expire = (cnt == last);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/ebc_strobe_gen.sv
module ebc_strobe_gen #(
   parameter int LANES = 2
) (
   input  logic             in_addr_ph,
   input  logic             in_strb_ph,
   input  logic             write,
   input  logic [LANES-1:0] lanes,
   output logic             ale,
   output logic             en_n,
   output logic [LANES-1:0] we_n
);
   always_comb begin
      ale  = in_addr_ph;
      en_n = !in_strb_ph;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_comb we_n[g] = !(in_strb_ph && write && lanes[g]);
   end
endmodule

// File: rtl/ebc_ctrl.sv
module ebc_ctrl
   import ebc_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int ALE_CLKS  = 2,
   parameter int STRB_CLKS = 2,
   parameter int MULT      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_word,
   input  logic              wait_dis,
   input  logic              wait_mode,
   input  logic              bus16,
   input  logic              addr_internal,
   output logic              ale,
   output logic              en_n,
   output logic              we_lo_n,
   output logic              we_hi_n,
   output logic [1:0]        lane_sel,
   output logic [ADDR_W-1:0] cyc_addr,
   output logic              done
);
   if (ADDR_W < 2 || ALE_CLKS < 2 || STRB_CLKS < 2 || MULT < 2) begin : g_bad_cfg
      $error("ebc_ctrl: ADDR_W, ALE_CLKS, STRB_CLKS and MULT must each be at least 2");
   end

   ebc_phase_e        phase;
   logic              second_q;
   logic              split_q, stretch_q, lo_only_q, write_q, word_q, bus16_q;
   logic [ADDR_W-1:0] addr_q;
   logic              split_d, stretch_d;
   logic              expire, restart, accept, last_byte;
   logic [1:0]        we_n;

   ebc_plan u_plan (
      .word     (req_word),
      .addr0    (req_addr[0]),
      .bus16    (bus16),
      .wait_dis (wait_dis),
      .internal (addr_internal),
      .split    (split_d),
      .stretch  (stretch_d)
   );

   ebc_phase_timer #(
      .ALE_CLKS  (ALE_CLKS),
      .STRB_CLKS (STRB_CLKS),
      .MULT      (MULT)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .in_strb (phase == PH_STRB),
      .stretch (stretch_q),
      .lo_only (lo_only_q),
      .expire  (expire)
   );

   always_comb begin
      accept    = (phase == PH_IDLE) && req_valid;
      restart   = (phase == PH_IDLE) || expire;
      last_byte = !split_q || second_q;
      cyc_addr  = addr_q + ADDR_W'(second_q);
      lane_sel  = (phase == PH_IDLE) ? 2'b00
                : lane_of(word_q && !split_q, bus16_q, cyc_addr[0]);
      done      = (phase == PH_STRB) && expire && last_byte;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         second_q  <= 1'b0;
         split_q   <= 1'b0;
         stretch_q <= 1'b0;
         lo_only_q <= 1'b0;
         write_q   <= 1'b0;
         word_q    <= 1'b0;
         bus16_q   <= 1'b0;
         addr_q    <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (accept) begin
               phase     <= PH_ADDR;
               second_q  <= 1'b0;
               split_q   <= split_d;
               stretch_q <= stretch_d;
               lo_only_q <= wait_mode;
               write_q   <= req_write;
               word_q    <= req_word;
               bus16_q   <= bus16;
               addr_q    <= req_addr;
            end
            PH_ADDR: if (expire) phase <= PH_STRB;
            PH_STRB: if (expire) begin
               if (last_byte) phase <= PH_IDLE;
               else begin
                  phase    <= PH_ADDR;
                  second_q <= 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   ebc_strobe_gen #(.LANES(2)) u_strobe (
      .in_addr_ph (phase == PH_ADDR),
      .in_strb_ph (phase == PH_STRB),
      .write      (write_q),
      .lanes      (lane_sel),
      .ale        (ale),
      .en_n       (en_n),
      .we_n       (we_n)
   );

   assign we_lo_n = we_n[0];
   assign we_hi_n = we_n[1];
endmodule

// File: rtl/ebc_ctrl_chk.sv
module ebc_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ale,
   input logic       en_n,
   input logic       we_lo_n,
   input logic       we_hi_n,
   input logic [1:0] lane_sel,
   input logic       done
);
   AST_ALE_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ale && !en_n)); // R2
   AST_ALE_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ale) |=> ale); // R2
   AST_EN_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_n) |=> !en_n); // R2
   AST_WE_INSIDE_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_lo_n || !we_hi_n) |-> !en_n); // R9
   AST_WE_HI_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      !we_hi_n |-> lane_sel[1]); // R8
   AST_WE_LO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      !we_lo_n |-> lane_sel[0]); // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_DONE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !en_n); // R10
   AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (en_n && !ale && lane_sel == 2'b00)); // R10
endmodule

bind ebc_ctrl ebc_ctrl_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ale      (ale),
   .en_n     (en_n),
   .we_lo_n  (we_lo_n),
   .we_hi_n  (we_hi_n),
   .lane_sel (lane_sel),
   .done     (done)
);

// File: tb/tb_ebc_ctrl.sv
module tb_ebc_ctrl;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_write = 1'b0, req_word = 1'b0;
   logic          wait_dis = 1'b0, wait_mode = 1'b0, bus16 = 1'b0, addr_internal = 1'b0;
   logic          ale, en_n, we_lo_n, we_hi_n, done;
   logic [1:0]    lane_sel;
   logic [AW-1:0] cyc_addr;

   int nvec = 0;
   int nerr = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   ebc_ctrl #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_word(req_word), .wait_dis(wait_dis),
      .wait_mode(wait_mode), .bus16(bus16), .addr_internal(addr_internal),
      .ale(ale), .en_n(en_n), .we_lo_n(we_lo_n), .we_hi_n(we_hi_n),
      .lane_sel(lane_sel), .cyc_addr(cyc_addr), .done(done)
   );

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      nvec++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic idle_check(input string tag);
      cmp(tag, "ale", ale, 0);
      cmp(tag, "en_n", en_n, 1);
      cmp(tag, "we_lo_n", we_lo_n, 1);
      cmp(tag, "we_hi_n", we_hi_n, 1);
      cmp(tag, "lane_sel", lane_sel, 0);
      cmp(tag, "done", done, 0);
   endtask

   task automatic run_one(input logic wr, input logic wd16, input logic wdis,
                          input logic wmode, input logic b16, input logic intl,
                          input logic [AW-1:0] addr);
      bit    stretch  = !wdis && !intl;
      int    ale_len  = (stretch && !wmode) ? 4 : 2;
      int    en_len   = stretch ? 4 : 2;
      bit    whole    = wd16 && b16 && !addr[0];
      int    nbytes   = (wd16 && !whole) ? 2 : 1;
      string ttag;
      if (stretch)                 ttag = wmode ? "R3" : "R4";
      else if (intl && !wdis)      ttag = "R5";
      else if (wdis && !intl)      ttag = "R5";
      else                         ttag = "R2";
      // present the request, accepted at the next rising edge
      @(negedge clk);
      req_valid = 1'b1; req_addr = addr; req_write = wr; req_word = wd16;
      wait_dis = wdis; wait_mode = wmode; bus16 = b16; addr_internal = intl;
      for (int b = 0; b < nbytes; b++) begin
         logic [AW-1:0] ba = addr + AW'(b);
         logic [1:0]    ln = whole ? 2'b11 : ((b16 && ba[0]) ? 2'b10 : 2'b01);
         string         ltag = whole ? "R6" : "R8";
         for (int c = 0; c < ale_len + en_len; c++) begin
            bit in_e = (c >= ale_len);
            bit lastc = in_e && (c == ale_len + en_len - 1) && (b == nbytes - 1);
            @(negedge clk);
            // R11: scramble every input while the transfer runs
            req_valid = 1'b1; req_addr = ~addr; req_write = ~wr; req_word = ~wd16;
            wait_dis = ~wdis; wait_mode = ~wmode; bus16 = ~b16; addr_internal = ~intl;
            cmp(ttag, "ale", ale, in_e ? 0 : 1);
            cmp(ttag, "en_n", en_n, in_e ? 0 : 1);
            cmp(ltag, "lane_sel", lane_sel, ln);
            cmp("R7", "cyc_addr", cyc_addr, ba);
            cmp("R9", "we_lo_n", we_lo_n, (in_e && wr && ln[0]) ? 0 : 1);
            cmp("R9", "we_hi_n", we_hi_n, (in_e && wr && ln[1]) ? 0 : 1);
            cmp("R10", "done", done, lastc ? 1 : 0);
            if (lastc) req_valid = 1'b0;
         end
      end
      // R11: valid was held high throughout, yet no new transfer started
      @(negedge clk);
      idle_check("R11");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      idle_check("R1");
      rst_n = 1'b1;
      @(negedge clk);
      idle_check("R1");
      for (int i = 0; i < 128; i++) begin
         logic [AW-1:0] a;
         a = (i % 5 == 0) ? {{(AW-1){1'b1}}, i[0]} : {AW'(i * 37 + 4)} ^ AW'(i[0]) & ~AW'(1) | AW'(i[0]);
         a[0] = i[0];
         run_one(i[1], i[2], i[3], i[4], i[5], i[6], a);
      end
      // R7: word at the top address on a narrow bus wraps to zero
      run_one(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, {AW{1'b1}});
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nerr++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end
endmodule